// File: doc/BRIEF.md
# Program Sequencer with Return-Address Stack

This block keeps the program counter of a small I/O processor. Each time the step strobe is high on a rising clock edge, it chooses the next instruction address. The choice comes from the flow-control class that the decoder presents. The classes are: fall through to the next address, jump without condition, branch on the zero flag (set or clear), call a subroutine, or return from one. The instruction fetch reads the current counter from the `pc` port. The decoder supplies the class, the branch or jump target, and the zero flag that the last compare or ALU operation left behind.

Calls and returns use a small hardware stack of return addresses. A call saves the address that follows the calling instruction and then jumps. A return resumes at the most recently saved address. The equal and not-equal branches are the same operations as the zero and not-zero branches, so the decoder maps them onto the same class codes. A halt is coded as a branch or jump to its own address, so the counter simply stays where it is. A call made while the stack is full, or a return made while it is empty, sets a sticky fault flag and leaves the stack contents as they were.

Top module: `pc_sequencer`

## Requirements
- R1: After reset, `pc` is 0, the stack is empty, and `stackOverflow` and `stackUnderflow` are both 0.
- R2: On a clock edge with `step` low, `pc`, the stack and both flags keep their values.
- R3: With `step` high, flow code 0 (sequential), and the unused codes 6 and 7, set `pc` to `pc`+1, wrapping modulo 2^PC_W.
- R4: With `step` high, flow code 1 (jump) loads `target` into `pc` with no condition.
- R5: Flow code 4 (branch if zero, also used for branch if equal) loads `target` when `zeroFlag` is 1 and otherwise advances `pc` by one. Flow code 5 (branch if not zero, also used for not-equal) loads `target` when `zeroFlag` is 0 and otherwise advances by one.
- R6: A jump or taken branch whose `target` equals the current `pc` (halt) keeps `pc` unchanged on every later step.
- R7: Flow code 2 (call) pushes `pc`+1 and loads `target`. Flow code 3 (return) pops the most recent entry into `pc`. Calls nest in last-in, first-out order up to DEPTH (default 4) entries.
- R8: A call made while DEPTH entries are stored sets `stackOverflow`. It leaves the stored entries unchanged and still loads `target` into `pc`.
- R9: A return made while the stack is empty sets `stackUnderflow` and advances `pc` by one.
- R10: Once set, `stackOverflow` and `stackUnderflow` stay at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| step | input | 1 | Advance the sequencer on this edge |
| flow | input | 3 | Flow-control class of the current instruction (codes in R3 to R9) |
| target | input | PC_W | Jump, branch or call destination |
| zeroFlag | input | 1 | Zero/equal condition from the last compare or ALU operation |
| pc | output | PC_W | Current program counter |
| stackOverflow | output | 1 | Sticky: a call was made with the stack full |
| stackUnderflow | output | 1 | Sticky: a return was made with the stack empty |

## Verification
The assertions take for granted that `flow`, `target` and `zeroFlag` have known values whenever `step` is high. They also take for granted that `rstN` is held low across at least one rising edge before the first step. The bench drives every input from known values at the falling edge. It holds reset low for several cycles before the first step, and it applies reset again only between steps. The stimulus mixes directed sequences with a random run. The directed sequences are: nested calls past full depth, returns past empty, halt loops and counter wrap. The random run is weighted toward calls and returns, so both the full and the empty stack boundaries are crossed many times.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  localparam logic [2:0] FLOW_SEQ  = 3'd0;
  localparam logic [2:0] FLOW_JUMP = 3'd1;
  localparam logic [2:0] FLOW_CALL = 3'd2;
  localparam logic [2:0] FLOW_RET  = 3'd3;
  localparam logic [2:0] FLOW_BZ   = 3'd4;
  localparam logic [2:0] FLOW_BNZ  = 3'd5;

  // Strobes from control to datapath
  typedef struct packed {
    logic pcLoadTarget;
    logic pcLoadTop;
    logic pcIncr;
    logic push;
    logic pop;
    logic setOvf;
    logic setUnf;
  } seqStrobeT;

endpackage

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
  import pcseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       step,
  input  logic [2:0] flow,
  input  logic       zeroFlag,
  input  logic       stackFull,
  input  logic       stackEmpty,
  output seqStrobeT  strobe
);

  logic takeBranch;

  assign takeBranch = ((flow == FLOW_BZ)  &&  zeroFlag) ||
                      ((flow == FLOW_BNZ) && !zeroFlag);

  always_comb begin
    strobe = '0;
    if (step) begin
      unique case (flow)
        FLOW_JUMP: strobe.pcLoadTarget = 1'b1;
        FLOW_CALL: begin
          strobe.pcLoadTarget = 1'b1;
          strobe.push         = !stackFull;
          strobe.setOvf       = stackFull;
        end
        FLOW_RET: begin
          strobe.pcLoadTop = !stackEmpty;
          strobe.pop       = !stackEmpty;
          strobe.pcIncr    = stackEmpty;
          strobe.setUnf    = stackEmpty;
        end
        FLOW_BZ, FLOW_BNZ: begin
          strobe.pcLoadTarget = takeBranch;
          strobe.pcIncr       = !takeBranch;
        end
        default: strobe.pcIncr = 1'b1;
      endcase
    end
  end

  // R8: never push into a full stack
  a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> !stackFull);

  // R9: never pop an empty stack
  a_r9_no_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> !stackEmpty);

  // R3: at most one source for the next counter value
  a_r3_one_source: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.pcLoadTarget, strobe.pcLoadTop, strobe.pcIncr}));

  // R2: no strobe without step
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !step |-> (strobe == '0));

endmodule

// File: rtl/pcseq_dp.sv
module pcseq_dp
  import pcseq_pkg::*;
#(
  parameter int PC_W  = 12,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  seqStrobeT       strobe,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc,
  output logic            stackFull,
  output logic            stackEmpty,
  output logic            ovfFlag,
  output logic            unfFlag
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PC_W-1:0]  stackMem [DEPTH];
  logic [CNT_W-1:0] count;
  logic [PC_W-1:0]  pcPlusOne;
  logic [PC_W-1:0]  topVal;

  assign pcPlusOne  = pc + 1'b1;
  assign stackFull  = (count == CNT_W'(DEPTH));
  assign stackEmpty = (count == '0);

  always_comb begin
    topVal = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CNT_W'(i + 1) == count) topVal = stackMem[i];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (strobe.push && (count == CNT_W'(g))) stackMem[g] <= pcPlusOne;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc      <= '0;
      count   <= '0;
      ovfFlag <= 1'b0;
      unfFlag <= 1'b0;
    end else begin
      if (strobe.pcLoadTarget)   pc <= target;
      else if (strobe.pcLoadTop) pc <= topVal;
      else if (strobe.pcIncr)    pc <= pcPlusOne;
      if (strobe.push)      count <= count + 1'b1;
      else if (strobe.pop)  count <= count - 1'b1;
      if (strobe.setOvf) ovfFlag <= 1'b1;
      if (strobe.setUnf) unfFlag <= 1'b1;
    end
  end

  // R4: target load lands on the next edge
  a_r4_target_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pcLoadTarget |=> (pc == $past(target)));

  // R7: a pop shrinks the stack by one
  a_r7_pop_count: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |=> (count == $past(count) - 1'b1));

  // R7: occupancy never exceeds the depth
  a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R2: an idle cycle leaves the counter alone
  a_r2_hold_pc: assert property (@(posedge clk) disable iff (!rstN)
    (strobe == '0) |=> $stable(pc));

  // R10: fault flags are sticky
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |=> ovfFlag);
  a_r10_unf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    unfFlag |=> unfFlag);

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int PC_W  = 12,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            step,
  input  logic [2:0]      flow,
  input  logic [PC_W-1:0] target,
  input  logic            zeroFlag,
  output logic [PC_W-1:0] pc,
  output logic            stackOverflow,
  output logic            stackUnderflow
);

  seqStrobeT strobe;
  logic      stackFull;
  logic      stackEmpty;

  pcseq_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .step       (step),
    .flow       (flow),
    .zeroFlag   (zeroFlag),
    .stackFull  (stackFull),
    .stackEmpty (stackEmpty),
    .strobe     (strobe)
  );

  pcseq_dp #(.PC_W(PC_W), .DEPTH(DEPTH)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .target     (target),
    .pc         (pc),
    .stackFull  (stackFull),
    .stackEmpty (stackEmpty),
    .ovfFlag    (stackOverflow),
    .unfFlag    (stackUnderflow)
  );

endmodule

// File: tb/pc_sequencer_test.sv
module pc_sequencer_test;

  localparam int PC_W  = 12;
  localparam int DEPTH = 4;
  localparam int MASK  = (1 << PC_W) - 1;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            step = 1'b0;
  logic [2:0]      flow = 3'd0;
  logic [PC_W-1:0] target = '0;
  logic            zeroFlag = 1'b0;
  logic [PC_W-1:0] pc;
  logic            stackOverflow;
  logic            stackUnderflow;

  int tests = 0;
  int fails = 0;

  // Reference model state
  int mPc = 0;
  int mStk[$];
  bit mOvf = 0;
  bit mUnf = 0;

  always #2 clk = ~clk;

  pc_sequencer #(.PC_W(PC_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .step(step), .flow(flow), .target(target),
    .zeroFlag(zeroFlag), .pc(pc), .stackOverflow(stackOverflow),
    .stackUnderflow(stackUnderflow)
  );

  task automatic compare(input string req);
    tests++;
    if (pc !== PC_W'(mPc) || stackOverflow !== mOvf || stackUnderflow !== mUnf) begin
      fails++;
      $display("FAIL %s: pc=%0h ovf=%0b unf=%0b expected pc=%0h ovf=%0b unf=%0b",
               req, pc, stackOverflow, stackUnderflow, mPc, mOvf, mUnf);
    end
  endtask

  function automatic string reqOf(input bit s, input int f);
    if (!s) return "R2";
    case (f)
      1: return "R4";
      2: return (mStk.size() >= DEPTH) ? "R8" : "R7";
      3: return (mStk.size() == 0) ? "R9" : "R7";
      4, 5: return "R5";
      default: return "R3";
    endcase
  endfunction

  // Called at a falling edge: drive, predict, then check at the next falling edge
  task automatic applyStep(input bit s, input int f, input int t, input bit z);
    string req;
    req = reqOf(s, f);
    step = s; flow = 3'(f); target = PC_W'(t); zeroFlag = z;
    if (s) begin
      case (f)
        1: mPc = t & MASK;
        2: begin
          if (mStk.size() < DEPTH) mStk.push_back((mPc + 1) & MASK);
          else mOvf = 1;
          mPc = t & MASK;
        end
        3: begin
          if (mStk.size() > 0) mPc = mStk.pop_back();
          else begin mUnf = 1; mPc = (mPc + 1) & MASK; end
        end
        4: mPc = z ? (t & MASK) : ((mPc + 1) & MASK);
        5: mPc = !z ? (t & MASK) : ((mPc + 1) & MASK);
        default: mPc = (mPc + 1) & MASK;
      endcase
    end
    @(negedge clk);
    compare(req);
  endtask

  task automatic doReset();
    step = 0;
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    mPc = 0; mOvf = 0; mUnf = 0;
    mStk.delete();
    compare("R1");
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();

    // R3: sequential steps, unused codes 6 and 7
    applyStep(1, 0, 0, 0);
    applyStep(1, 6, 12'h555, 1);
    applyStep(1, 7, 12'h555, 0);
    // R2: idle cycles with busy inputs
    applyStep(0, 1, 12'h123, 1);
    applyStep(0, 2, 12'h321, 0);
    // R4: jump, then R3 wrap from the top address
    applyStep(1, 1, 12'hFFF, 0);
    applyStep(1, 0, 0, 0);
    // R5: both polarities of both branches
    applyStep(1, 4, 12'h040, 1);
    applyStep(1, 4, 12'h080, 0);
    applyStep(1, 5, 12'h0C0, 0);
    applyStep(1, 5, 12'h100, 1);
    // R6: halt loops via jump and taken branch
    applyStep(1, 1, 12'h200, 0);
    for (int i = 0; i < 3; i++) applyStep(1, 1, 12'h200, 0);
    for (int i = 0; i < 3; i++) applyStep(1, 4, 12'h200, 1);
    // R7 nesting, then R8: calls past full depth
    for (int i = 0; i < DEPTH + 2; i++) applyStep(1, 2, 12'h300 + 16 * i, 0);
    // R7 unwinding, then R9: returns past empty
    for (int i = 0; i < DEPTH + 2; i++) applyStep(1, 3, 0, 0);
    // R10: flags hold through further activity
    applyStep(1, 0, 0, 0);
    applyStep(1, 2, 12'h010, 0);
    applyStep(1, 3, 0, 0);
    // R1: reset clears flags and stack
    doReset();
    applyStep(1, 3, 0, 0);   // R9 right after reset: stack must be empty
    doReset();

    // Random run weighted toward calls and returns
    for (int i = 0; i < 3000; i++) begin
      int r;
      int f;
      r = $urandom_range(0, 99);
      if (r < 30) f = 2;
      else if (r < 60) f = 3;
      else f = $urandom_range(0, 7);
      applyStep($urandom_range(0, 9) != 0, f, $urandom_range(0, MASK), 1'($urandom_range(0, 1)));
      if (i % 1000 == 999) doReset();
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule